// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the target end of a 4-bit multiplexed firmware bus. A host marks each transaction with an active-low frame strobe and moves every field as one nibble per clock. The target decodes the frame to find a transaction start code and its own device number. It then collects a seven-nibble address and a size code. For a write it takes in one data byte. After the host hands over the bus, the target drives sync codes. For a read it then returns one data byte. In both cases it closes by driving all ones for a single cycle and then releasing the bus.

The data path is split into an input nibble, an output nibble and an output enable, so that the pad ring or a bench can build the shared wire. A small behavioural byte array sits behind a single-byte port. Its index is the low bits of the assembled address. A configurable number of wait syncs models the access latency of that array. A standby flag is high whenever the frame strobe is idle and no transaction is in flight.

Top module: `fwbus_target`

## Requirements
- R1: After reset the target does not drive the bus (`bus_oe` low), standby is high, and every array byte reads back as 8'h00.
- R2: While `frame_n` stays low for several cycles, the code on the bus in the last low cycle alone selects the transaction: 4'hD means read and 4'hE means write.
- R3: The nibble in the first cycle after `frame_n` rises is the device number. If it differs from `id_cfg`, the target never drives the bus for the rest of that frame.
- R4: The seven nibbles after the device number form a 28-bit address, most significant nibble first. The array index is the low address bits.
- R5: The nibble after the address is the size code. Only 4'h0 (one byte) is served. Any other value leaves the bus undriven and the array unchanged.
- R6: A data byte moves as two nibbles, the low nibble first and the high nibble second, for both write capture and read return.
- R7: After the two host turnaround cycles, the target drives WAIT_CYC cycles of 4'h5, then one cycle of 4'h0 (ready). Read data follows the ready cycle directly.
- R8: After the read data or the write ready sync, the target drives 4'hF for one cycle and then floats for one cycle. After that, standby is high again if `frame_n` is high.
- R9: Pulling `frame_n` low in the middle of a transaction makes the target stop driving in the next cycle and decode a new start code. An aborted write that has not yet reached ready leaves the array unchanged.
- R10: A start code other than 4'hD or 4'hE is ignored: the bus stays undriven until the next frame.
- R11: Standby is low from the start field until the closing turnaround ends.
- R12: The target does not drive during the two host turnaround cycles that follow the size code (read) or the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; fields are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_i | input | 4 | Nibble seen on the shared bus |
| id_cfg | input | 4 | Device number this target answers to |
| bus_o | output | 4 | Nibble driven by the target when enabled |
| bus_oe | output | 1 | Output enable of the target's bus driver |
| standby | output | 1 | High when the strobe is idle and nothing is in flight |

## Verification
The bench holds the strobe low across a write code followed by a read code. A target that latched the first start code would then run a write and never return data. It writes to address 0x0000005 and reads from 0x5000000; if the address order were reversed, the two would hit the same byte. The byte 0x3C is written and read back nibble by nibble, which exposes a swapped data order. A write is aborted during its wait syncs and the location is read afterwards. A design that commits too early, or keeps driving after the strobe falls, shows a changed byte or an enabled driver. Frames with a wrong device number, a wrong size and an unknown start code must all leave the bus floating and the target in standby at the end.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_SKIP,
    S_ADDR,
    S_SIZE,
    S_WLO,
    S_WHI,
    S_HTAR1,
    S_HTAR2,
    S_SYNC,
    S_RLO,
    S_RHI,
    S_ETAR1,
    S_ETAR2
  } fwb_state_e;

  localparam logic [3:0] CODE_RD    = 4'hD;
  localparam logic [3:0] CODE_WR    = 4'hE;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_WAIT  = 4'h5;
  localparam logic [3:0] NIB_ONES   = 4'hF;
  localparam logic [3:0] SIZE_ONE   = 4'h0;

  localparam int ADDR_NIBS = 7;
  localparam int ADDR_W    = 4 * ADDR_NIBS;
  localparam int BYTE_W    = 8;

endpackage

// File: rtl/fwb_mem.sv
module fwb_mem
  import fwb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int IW = $clog2(DEPTH);

  logic [BYTE_W-1:0] arr_q [DEPTH];
  logic [IW-1:0]     idx;
  logic              unused_addr_hi;

  assign idx            = addr[IW-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:IW];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          arr_q[g] <= '0;
        end else if (we && (idx == IW'(g))) begin
          arr_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = arr_q[idx];

endmodule

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_i,
  input  logic [3:0]        id_cfg,
  output logic [3:0]        bus_o,
  output logic              bus_oe,
  output logic              standby,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int WCW = $clog2(WAIT_CYC + 2);
  localparam int NCW = $clog2(ADDR_NIBS + 1);
  localparam logic [WCW-1:0] WAIT_LAST = WCW'(WAIT_CYC);
  localparam logic [NCW-1:0] NIB_LAST  = NCW'(ADDR_NIBS - 1);

  fwb_state_e        state_q, state_d;
  logic [3:0]        code_q, code_d;
  logic              is_wr_q, is_wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [3:0]        dlo_q, dlo_d;
  logic [3:0]        dhi_q, dhi_d;
  logic [NCW-1:0]    ncnt_q, ncnt_d;
  logic [WCW-1:0]    wcnt_q, wcnt_d;
  logic              commit;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    is_wr_d = is_wr_q;
    addr_d  = addr_q;
    dlo_d   = dlo_q;
    dhi_d   = dhi_q;
    ncnt_d  = ncnt_q;
    wcnt_d  = wcnt_q;
    commit  = 1'b0;
    if (!frame_n) begin
      // Any low strobe cycle restarts decoding; the latest code wins.
      state_d = S_START;
      code_d  = bus_i;
    end else begin
      unique case (state_q)
        S_IDLE: state_d = S_IDLE;
        S_START: begin
          if ((code_q == CODE_RD || code_q == CODE_WR) && bus_i == id_cfg) begin
            state_d = S_ADDR;
            is_wr_d = (code_q == CODE_WR);
            ncnt_d  = '0;
          end else begin
            state_d = S_SKIP;
          end
        end
        S_SKIP: state_d = S_SKIP;
        S_ADDR: begin
          addr_d = {addr_q[ADDR_W-5:0], bus_i};
          if (ncnt_q == NIB_LAST) begin
            state_d = S_SIZE;
          end else begin
            ncnt_d = ncnt_q + 1'b1;
          end
        end
        S_SIZE: begin
          if (bus_i != SIZE_ONE) begin
            state_d = S_SKIP;
          end else if (is_wr_q) begin
            state_d = S_WLO;
          end else begin
            state_d = S_HTAR1;
          end
        end
        S_WLO: begin
          dlo_d   = bus_i;
          state_d = S_WHI;
        end
        S_WHI: begin
          dhi_d   = bus_i;
          state_d = S_HTAR1;
        end
        S_HTAR1: state_d = S_HTAR2;
        S_HTAR2: begin
          state_d = S_SYNC;
          wcnt_d  = '0;
        end
        S_SYNC: begin
          if (wcnt_q == WAIT_LAST) begin
            if (is_wr_q) begin
              commit  = 1'b1;
              state_d = S_ETAR1;
            end else begin
              state_d = S_RLO;
            end
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
        S_RLO:   state_d = S_RHI;
        S_RHI:   state_d = S_ETAR1;
        S_ETAR1: state_d = S_ETAR2;
        S_ETAR2: state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= '0;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      ncnt_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      is_wr_q <= is_wr_d;
      addr_q  <= addr_d;
      dlo_q   <= dlo_d;
      dhi_q   <= dhi_d;
      ncnt_q  <= ncnt_d;
      wcnt_q  <= wcnt_d;
    end
  end

  // Bus driver: Moore outputs from the registered state
  always_comb begin
    bus_oe = 1'b0;
    bus_o  = NIB_ONES;
    unique case (state_q)
      S_SYNC: begin
        bus_oe = 1'b1;
        bus_o  = (wcnt_q == WAIT_LAST) ? SYNC_READY : SYNC_WAIT;
      end
      S_RLO: begin
        bus_oe = 1'b1;
        bus_o  = mem_rdata[3:0];
      end
      S_RHI: begin
        bus_oe = 1'b1;
        bus_o  = mem_rdata[7:4];
      end
      S_ETAR1: begin
        bus_oe = 1'b1;
        bus_o  = NIB_ONES;
      end
      default: begin
        bus_oe = 1'b0;
        bus_o  = NIB_ONES;
      end
    endcase
  end

  assign standby   = frame_n && (state_q == S_IDLE || state_q == S_SKIP);
  assign mem_addr  = addr_q;
  assign mem_we    = commit;
  assign mem_wdata = {dhi_q, dlo_q};

  // Assertions
  p_float_on_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !bus_oe);

  p_write_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (frame_n && is_wr_q));

  p_ready_before_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RLO) |-> ($past(state_q) == S_SYNC && $past(bus_o) == SYNC_READY));

  p_ones_then_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ETAR2) |-> ($past(bus_oe) && $past(bus_o) == NIB_ONES && !bus_oe));

  p_host_tar_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> ($past(state_q) == S_HTAR2));

  p_standby_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!bus_oe && !mem_we));

endmodule

// File: rtl/fwbus_target.sv
module fwbus_target
  import fwb_pkg::*;
#(
  parameter int WAIT_CYC = 2,
  parameter int DEPTH    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] bus_i,
  input  logic [3:0] id_cfg,
  output logic [3:0] bus_o,
  output logic       bus_oe,
  output logic       standby
);

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;

  fwb_seq #(
    .WAIT_CYC(WAIT_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .bus_i    (bus_i),
    .id_cfg   (id_cfg),
    .bus_o    (bus_o),
    .bus_oe   (bus_oe),
    .standby  (standby),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  fwb_mem #(
    .DEPTH(DEPTH)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (mem_addr),
    .we   (mem_we),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

endmodule

// File: tb/fwbus_target_bench.sv
module fwbus_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_N     = 2;
  localparam logic [3:0] MY_ID = 4'hA;

  logic       clk;
  logic       rst_n;
  logic       frame_n;
  logic [3:0] bus_i;
  logic [3:0] id_cfg;
  logic [3:0] bus_o;
  logic       bus_oe;
  logic       standby;

  int checks;
  int fails;

  logic       obs_oe;
  logic [3:0] obs_d;
  logic       obs_sb;

  fwbus_target #(.WAIT_CYC(WAIT_N), .DEPTH(16)) u_fwbus_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .frame_n(frame_n),
    .bus_i  (bus_i),
    .id_cfg (id_cfg),
    .bus_o  (bus_o),
    .bus_oe (bus_oe),
    .standby(standby)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one field at the falling edge, let one rising edge pass, observe.
  task automatic step(input logic f, input logic [3:0] n);
    frame_n = f;
    bus_i   = n;
    @(posedge clk);
    @(negedge clk);
    obs_oe = bus_oe;
    obs_d  = bus_o;
    obs_sb = standby;
  endtask

  task automatic send_addr(input logic [27:0] a);
    for (int i = 6; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
  endtask

  // Everything after the start field(s) of a read.
  task automatic read_body(input logic [27:0] a, input logic [7:0] exp);
    step(1'b1, MY_ID);
    chk(!obs_sb, "R11 standby during frame", int'(obs_sb), 0);
    send_addr(a);
    step(1'b1, 4'h0);
    chk(!obs_oe, "R12 quiet in host turnaround 1", int'(obs_oe), 0);
    step(1'b1, 4'hF);
    chk(!obs_oe, "R12 quiet in host turnaround 2", int'(obs_oe), 0);
    step(1'b1, 4'h0);
    for (int w = 0; w < WAIT_N; w++) begin
      chk(obs_oe && obs_d == 4'h5, "R7 wait sync", int'(obs_d), 5);
      step(1'b1, 4'h0);
    end
    chk(obs_oe && obs_d == 4'h0, "R7 ready sync", int'(obs_d), 0);
    step(1'b1, 4'h0);
    chk(obs_oe && obs_d == exp[3:0], "R6 low nibble first", int'(obs_d), int'(exp[3:0]));
    step(1'b1, 4'h0);
    chk(obs_oe && obs_d == exp[7:4], "R6 high nibble second", int'(obs_d), int'(exp[7:4]));
    step(1'b1, 4'h0);
    chk(obs_oe && obs_d == 4'hF, "R8 ones in closing turnaround", int'(obs_d), 15);
    step(1'b1, 4'h0);
    chk(!obs_oe, "R8 float after ones", int'(obs_oe), 0);
    step(1'b1, 4'h0);
    chk(obs_sb, "R8 standby after frame", int'(obs_sb), 1);
  endtask

  task automatic do_read(input logic [27:0] a, input logic [7:0] exp);
    step(1'b0, 4'hD);
    read_body(a, exp);
  endtask

  // Write; when abort is set, the strobe falls with a read code during the first sync.
  task automatic do_write(input logic [27:0] a, input logic [7:0] d, input logic abort);
    step(1'b0, 4'hE);
    step(1'b1, MY_ID);
    send_addr(a);
    step(1'b1, 4'h0);
    step(1'b1, d[3:0]);
    step(1'b1, d[7:4]);
    chk(!obs_oe, "R12 quiet after write data", int'(obs_oe), 0);
    step(1'b1, 4'hF);
    step(1'b1, 4'h0);
    chk(obs_oe, "R7 write sync driven", int'(obs_oe), 1);
    if (abort) begin
      step(1'b0, 4'hD);
      chk(!obs_oe, "R9 release on abort", int'(obs_oe), 0);
      chk(!obs_sb, "R9 new frame decoding", int'(obs_sb), 0);
      return;
    end
    for (int w = 0; w < WAIT_N; w++) step(1'b1, 4'h0);
    chk(obs_oe && obs_d == 4'h0, "R7 write ready", int'(obs_d), 0);
    step(1'b1, 4'h0);
    chk(obs_oe && obs_d == 4'hF, "R8 write closing ones", int'(obs_d), 15);
    step(1'b1, 4'h0);
    chk(!obs_oe, "R8 write closing float", int'(obs_oe), 0);
    step(1'b1, 4'h0);
    chk(obs_sb, "R8 write standby after", int'(obs_sb), 1);
  endtask

  // A frame the target must not answer.
  task automatic silent_frame(input logic [3:0] code, input logic [3:0] id,
                              input logic [3:0] size, input string tag);
    logic drove;
    drove = 1'b0;
    step(1'b0, code);
    step(1'b1, id);
    drove |= obs_oe;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 4'h0);
      drove |= obs_oe;
    end
    step(1'b1, size);
    drove |= obs_oe;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 4'h0);
      drove |= obs_oe;
    end
    chk(!drove, tag, int'(drove), 0);
    chk(obs_sb, tag, int'(obs_sb), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks  = 0;
    fails   = 0;
    rst_n   = 1'b0;
    frame_n = 1'b1;
    bus_i   = 4'h0;
    id_cfg  = MY_ID;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!bus_oe, "R1 bus undriven", int'(bus_oe), 0);
    chk(standby, "R1 standby", int'(standby), 1);
    do_read(28'h0000003, 8'h00);  // R1 array cleared

    // R6: nibble order of data
    do_write(28'h0000002, 8'h3C, 1'b0);
    do_read(28'h0000002, 8'h3C);

    // R4: most significant nibble first
    do_write(28'h0000005, 8'h5A, 1'b0);
    do_read(28'h5000000, 8'h00);
    do_read(28'h0000005, 8'h5A);

    // R2: last start code while the strobe is low wins
    step(1'b0, 4'hE);
    step(1'b0, 4'hD);
    read_body(28'h0000005, 8'h5A);

    // R9: abort during write sync, no commit
    do_write(28'h0000007, 8'h42, 1'b0);
    do_write(28'h0000007, 8'h99, 1'b1);
    read_body(28'h0000007, 8'h42);

    // R3: wrong device number
    silent_frame(4'hD, 4'h3, 4'h0, "R3 other device ignored");
    // R5: unsupported size
    silent_frame(4'hE, MY_ID, 4'h1, "R5 size not one byte ignored");
    do_read(28'h0000000, 8'h00);  // R5 write with bad size left array alone
    // R10: unknown start code
    silent_frame(4'h3, MY_ID, 4'h0, "R10 unknown start code ignored");

    do_read(28'h0000007, 8'h42);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule